// File: doc/BRIEF.md
# Split Transaction Timeout Tracker

This block sits beside the asynchronous request transmitter of a serial-bus link layer. Once a request leaves, the tracker lowers its permit output. No further request may start until one of two things happens: a response comes back with the label of the pending request, or the split-transaction countdown runs out. The countdown is loaded from two control fields, whole seconds and units of 1/8000 second, and it advances on an external 8 kHz tick. If both fields are zero, no countdown is started, so any number of split transactions may be outstanding and software pairs them by label.

The tracker also gives a keep or discard verdict for each incoming response. A response is solicited when its label matches the pending label while the countdown is live. By default only solicited responses are kept. An accept-all control bit keeps every response. A broadcast-drop control bit discards broadcast packets whatever else applies. When the countdown expires, the tracker can raise a one-cycle timeout interrupt, gated by an enable input.

Top module: `split_txn_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_permit` is 1 and `timeout_irq` and `rsp_done` are 0.
- R2: `req_sent` in a cycle where `req_permit` is 1 and the timeout (`cfg_sec`, `cfg_frac`) is nonzero drives `req_permit` to 0 from the next cycle. It stays 0 until expiry or a matching response.
- R3: An armed countdown ends on exactly the `cfg_sec*TICKS_PER_SEC + cfg_frac`-th `tick` pulse counted after arming. `req_permit` is 1 in the cycle after that tick.
- R4: When the fraction count is zero and seconds remain, a tick reloads the fraction to `TICKS_PER_SEC-1` and takes one second off. Whole seconds therefore lengthen the wait by `TICKS_PER_SEC` ticks each.
- R5: `req_sent` with both timeout fields zero arms nothing. `req_permit` stays 1 and no interrupt follows.
- R6: On expiry, `timeout_irq` is 1 for exactly one cycle, the cycle after the final tick, and only if `irq_en` was 1 on that tick.
- R7: A response whose label equals the pending label, while the countdown runs and the response is not a dropped broadcast, stops the countdown. `req_permit` returns to 1 the next cycle. No interrupt is raised, even if a final tick arrives in the same cycle.
- R8: Each `rsp_valid` gives `rsp_done`=1 one cycle later, with `rsp_store` as the verdict. With `cfg_accept_all`=0, only solicited responses get `rsp_store`=1. Responses with no pending request, with a wrong label, or with an already expired label get 0.
- R9: With `cfg_accept_all`=1, every response that is not a dropped broadcast gets `rsp_store`=1.
- R10: With `cfg_drop_bcast`=1, a response with `rsp_bcast`=1 gets `rsp_store`=0. It never counts as a match, so the countdown keeps running.
- R11: `req_sent` while `req_permit` is 0 is ignored. The pending label and the countdown are unchanged.
- R12: Ticks while no countdown runs are not counted toward a later countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_sent | input | 1 | Strobe: a request started transmission |
| req_label | input | LABEL_W | Transaction label of that request |
| rsp_valid | input | 1 | Strobe: a response packet was received |
| rsp_label | input | LABEL_W | Transaction label of that response |
| rsp_bcast | input | 1 | The received response was broadcast |
| tick | input | 1 | One-cycle pulse at 8 kHz |
| cfg_sec | input | SEC_W | Timeout, whole seconds |
| cfg_frac | input | FRAC_W | Timeout, 1/TICKS_PER_SEC units |
| cfg_accept_all | input | 1 | Keep every response, solicited or not |
| cfg_drop_bcast | input | 1 | Discard broadcast responses |
| irq_en | input | 1 | Timeout interrupt enable |
| req_permit | output | 1 | Next request may start |
| rsp_done | output | 1 | Verdict valid for the previous response |
| rsp_store | output | 1 | Verdict: keep the response |
| timeout_irq | output | 1 | One-cycle timeout interrupt |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 10 and keeps the 3-bit seconds and 13-bit fraction widths. With that setting a countdown of several whole seconds ends within a few dozen ticks, so the fraction reload and the seconds decrement are exercised both in directed runs and in random runs. Random labels are drawn from a range of four, which makes matches, mismatches and late responses that hit an expired label all frequent.

// File: rtl/split_txn_pkg.sv
package split_txn_pkg;

  typedef enum logic [1:0] {
    VERDICT_BCAST_OUT = 2'd0,
    VERDICT_UNSOLIC   = 2'd1,
    VERDICT_ANY_OK    = 2'd2,
    VERDICT_SOLICITED = 2'd3
  } rsp_verdict_e;

  function automatic logic verdict_keeps(input rsp_verdict_e v);
    return (v == VERDICT_ANY_OK) || (v == VERDICT_SOLICITED);
  endfunction

endpackage

// File: rtl/split_countdown.sv
module split_countdown #(
  parameter int SEC_W         = 3,
  parameter int FRAC_W        = 13,
  parameter int TICKS_PER_SEC = 8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SEC_W-1:0]  load_sec,
  input  logic [FRAC_W-1:0] load_frac,
  input  logic              tick,
  input  logic              stop,
  output logic              running,
  output logic              expire
);

  localparam logic [FRAC_W-1:0] RELOAD = FRAC_W'(TICKS_PER_SEC - 1);

  logic [SEC_W-1:0]  sec_q;
  logic [FRAC_W-1:0] frac_q;
  logic              run_q;
  logic              last_unit;

  // sec_q == 0 while running implies frac_q >= 1 (zero load is never armed)
  assign last_unit = (sec_q == '0) && (frac_q == FRAC_W'(1));
  assign expire    = run_q && tick && !stop && last_unit;
  assign running   = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      sec_q  <= '0;
      frac_q <= '0;
    end else if (load) begin
      run_q  <= 1'b1;
      sec_q  <= load_sec;
      frac_q <= load_frac;
    end else if (run_q) begin
      if (stop) begin
        run_q <= 1'b0;
      end else if (tick) begin
        if (last_unit) begin
          run_q  <= 1'b0;
          frac_q <= '0;
        end else if (frac_q == '0) begin
          frac_q <= RELOAD;
          sec_q  <= sec_q - SEC_W'(1);
        end else begin
          frac_q <= frac_q - FRAC_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/rsp_screen.sv
module rsp_screen
  import split_txn_pkg::*;
#(
  parameter int LABEL_W = 6
) (
  input  logic               running,
  input  logic [LABEL_W-1:0] pend_label,
  input  logic               rsp_valid,
  input  logic [LABEL_W-1:0] rsp_label,
  input  logic               rsp_bcast,
  input  logic               accept_all,
  input  logic               drop_bcast,
  output logic               solicited,
  output logic               keep
);

  rsp_verdict_e verdict;
  logic         label_hit;
  logic         bcast_out;

  assign label_hit = running && (rsp_label == pend_label);
  assign bcast_out = rsp_bcast && drop_bcast;

  always_comb begin
    if (bcast_out)       verdict = VERDICT_BCAST_OUT;
    else if (label_hit)  verdict = VERDICT_SOLICITED;
    else if (accept_all) verdict = VERDICT_ANY_OK;
    else                 verdict = VERDICT_UNSOLIC;
  end

  assign solicited = rsp_valid && (verdict == VERDICT_SOLICITED);
  assign keep      = rsp_valid && verdict_keeps(verdict);

endmodule

// File: rtl/split_txn_guard.sv
module split_txn_guard #(
  parameter int LABEL_W       = 6,
  parameter int SEC_W         = 3,
  parameter int FRAC_W        = 13,
  parameter int TICKS_PER_SEC = 8000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_sent,
  input  logic [LABEL_W-1:0] req_label,
  input  logic               rsp_valid,
  input  logic [LABEL_W-1:0] rsp_label,
  input  logic               rsp_bcast,
  input  logic               tick,
  input  logic [SEC_W-1:0]   cfg_sec,
  input  logic [FRAC_W-1:0]  cfg_frac,
  input  logic               cfg_accept_all,
  input  logic               cfg_drop_bcast,
  input  logic               irq_en,
  output logic               req_permit,
  output logic               rsp_done,
  output logic               rsp_store,
  output logic               timeout_irq
);

  logic               running;
  logic               expire;
  logic               solicited;
  logic               keep;
  logic               arm;
  logic               nonzero_tmo;
  logic [LABEL_W-1:0] pend_label;

  assign nonzero_tmo = (cfg_sec != '0) || (cfg_frac != '0);
  assign arm         = req_sent && !running && nonzero_tmo;

  split_countdown #(
    .SEC_W        (SEC_W),
    .FRAC_W       (FRAC_W),
    .TICKS_PER_SEC(TICKS_PER_SEC)
  ) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (arm),
    .load_sec (cfg_sec),
    .load_frac(cfg_frac),
    .tick     (tick),
    .stop     (solicited),
    .running  (running),
    .expire   (expire)
  );

  rsp_screen #(
    .LABEL_W(LABEL_W)
  ) u_screen (
    .running   (running),
    .pend_label(pend_label),
    .rsp_valid (rsp_valid),
    .rsp_label (rsp_label),
    .rsp_bcast (rsp_bcast),
    .accept_all(cfg_accept_all),
    .drop_bcast(cfg_drop_bcast),
    .solicited (solicited),
    .keep      (keep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_label  <= '0;
      rsp_done    <= 1'b0;
      rsp_store   <= 1'b0;
      timeout_irq <= 1'b0;
    end else begin
      if (arm) pend_label <= req_label;
      rsp_done    <= rsp_valid;
      rsp_store   <= keep;
      timeout_irq <= expire && irq_en;
    end
  end

  assign req_permit = !running;

endmodule

// File: rtl/split_txn_guard_chk.sv
module split_txn_guard_chk #(
  parameter int LABEL_W = 6,
  parameter int SEC_W   = 3,
  parameter int FRAC_W  = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               req_sent,
  input logic               rsp_valid,
  input logic [LABEL_W-1:0] rsp_label,
  input logic               rsp_bcast,
  input logic [SEC_W-1:0]   cfg_sec,
  input logic [FRAC_W-1:0]  cfg_frac,
  input logic               cfg_accept_all,
  input logic               cfg_drop_bcast,
  input logic               irq_en,
  input logic [LABEL_W-1:0] pend_label,
  input logic               req_permit,
  input logic               rsp_done,
  input logic               rsp_store,
  input logic               timeout_irq
);

  logic zero_tmo;
  logic bcast_out;
  assign zero_tmo  = (cfg_sec == '0) && (cfg_frac == '0);
  assign bcast_out = rsp_bcast && cfg_drop_bcast;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (req_permit && !timeout_irq && !rsp_done));

  p_arm_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (req_sent && req_permit && !zero_tmo) |=> !req_permit);

  p_irq_frees_r3: assert property (@(posedge clk) disable iff (rst)
    timeout_irq |-> req_permit);

  p_zero_open_r5: assert property (@(posedge clk) disable iff (rst)
    (req_sent && req_permit && zero_tmo) |=> req_permit);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst)
    timeout_irq |=> !timeout_irq);

  p_irq_gated_r6: assert property (@(posedge clk) disable iff (rst)
    timeout_irq |-> $past(irq_en));

  p_match_frees_r7: assert property (@(posedge clk) disable iff (rst)
    (!req_permit && rsp_valid && !bcast_out && rsp_label == pend_label)
      |=> (req_permit && !timeout_irq && rsp_store));

  p_verdict_timing_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> rsp_done);

  p_store_needs_done_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_store |-> rsp_done);

  p_accept_all_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && cfg_accept_all && !bcast_out) |=> rsp_store);

  p_bcast_dropped_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && bcast_out) |=> !rsp_store);

  p_label_held_r11: assert property (@(posedge clk) disable iff (rst)
    (!req_permit && req_sent) |=> $stable(pend_label));

  p_idle_stays_r12: assert property (@(posedge clk) disable iff (rst)
    (req_permit && !req_sent) |=> req_permit);

endmodule

bind split_txn_guard split_txn_guard_chk #(
  .LABEL_W(LABEL_W),
  .SEC_W  (SEC_W),
  .FRAC_W (FRAC_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_sent      (req_sent),
  .rsp_valid     (rsp_valid),
  .rsp_label     (rsp_label),
  .rsp_bcast     (rsp_bcast),
  .cfg_sec       (cfg_sec),
  .cfg_frac      (cfg_frac),
  .cfg_accept_all(cfg_accept_all),
  .cfg_drop_bcast(cfg_drop_bcast),
  .irq_en        (irq_en),
  .pend_label    (pend_label),
  .req_permit    (req_permit),
  .rsp_done      (rsp_done),
  .rsp_store     (rsp_store),
  .timeout_irq   (timeout_irq)
);

// File: tb/sim_split_txn_guard.sv
`timescale 1ns/1ps
module sim_split_txn_guard;

  localparam int LW  = 6;
  localparam int SW  = 3;
  localparam int FW  = 13;
  localparam int TPS = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_sent = 1'b0;
  logic [LW-1:0] req_label = '0;
  logic          rsp_valid = 1'b0;
  logic [LW-1:0] rsp_label = '0;
  logic          rsp_bcast = 1'b0;
  logic          tick = 1'b0;
  logic [SW-1:0] cfg_sec = '0;
  logic [FW-1:0] cfg_frac = '0;
  logic          cfg_accept_all = 1'b0;
  logic          cfg_drop_bcast = 1'b0;
  logic          irq_en = 1'b0;
  logic          req_permit, rsp_done, rsp_store, timeout_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  split_txn_guard #(
    .LABEL_W(LW), .SEC_W(SW), .FRAC_W(FW), .TICKS_PER_SEC(TPS)
  ) u0 (
    .clk(clk), .rst(rst), .req_sent(req_sent), .req_label(req_label),
    .rsp_valid(rsp_valid), .rsp_label(rsp_label), .rsp_bcast(rsp_bcast),
    .tick(tick), .cfg_sec(cfg_sec), .cfg_frac(cfg_frac),
    .cfg_accept_all(cfg_accept_all), .cfg_drop_bcast(cfg_drop_bcast),
    .irq_en(irq_en), .req_permit(req_permit), .rsp_done(rsp_done),
    .rsp_store(rsp_store), .timeout_irq(timeout_irq)
  );

  // requirement-level model: remaining ticks as one integer
  bit          m_active = 1'b0;
  int          m_rem = 0;
  logic [LW-1:0] m_label = '0;
  bit          e_irq = 1'b0, e_done = 1'b0, e_store = 1'b0;

  function automatic int total_ticks(input logic [SW-1:0] s, input logic [FW-1:0] f);
    return int'(s) * TPS + int'(f);
  endfunction

  function automatic bit verdict(input bit act, input logic [LW-1:0] pl,
                                 input logic [LW-1:0] rl, input bit bc,
                                 input bit all, input bit dropb);
    if (bc && dropb) return 1'b0;
    if (all) return 1'b1;
    return act && (rl == pl);
  endfunction

  always @(posedge clk) begin
    bit sol;
    if (rst) begin
      m_active = 1'b0; e_irq = 1'b0; e_done = 1'b0; e_store = 1'b0;
    end else begin
      sol = m_active && rsp_valid && (rsp_label == m_label) && !(rsp_bcast && cfg_drop_bcast);
      e_done  = rsp_valid;
      e_store = rsp_valid && verdict(m_active, m_label, rsp_label, rsp_bcast,
                                     cfg_accept_all, cfg_drop_bcast);
      e_irq = 1'b0;
      if (m_active) begin
        if (sol) m_active = 1'b0;
        else if (tick) begin
          m_rem = m_rem - 1;
          if (m_rem == 0) begin
            m_active = 1'b0;
            e_irq = irq_en;
          end
        end
      end else if (req_sent && total_ticks(cfg_sec, cfg_frac) != 0) begin
        m_active = 1'b1;
        m_rem = total_ticks(cfg_sec, cfg_frac);
        m_label = req_label;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done_flag) begin
      check("R2 permit vs model", req_permit, !m_active);
      check("R6 irq vs model", timeout_irq, e_irq);
      check("R8 done vs model", rsp_done, e_done);
      check("R9 store vs model", rsp_store, e_store);
    end
  end

  task automatic finish_run();
    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done_flag) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic step(input bit rq, input int rl, input bit tk,
                      input bit rv, input int sl, input bit bc);
    req_sent = rq; req_label = LW'(rl); tick = tk;
    rsp_valid = rv; rsp_label = LW'(sl); rsp_bcast = bc;
    @(posedge clk);
    @(negedge clk);
    req_sent = 1'b0; tick = 1'b0; rsp_valid = 1'b0; rsp_bcast = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    cfg_sec = 0; cfg_frac = 5; irq_en = 1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R1 permit in reset", req_permit, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 permit after reset", req_permit, 1);
    check("R1 irq after reset", timeout_irq, 0);
    check("R1 done after reset", rsp_done, 0);
    cmp_en = 1'b1;

    // countdown of 5 fraction units
    step(1, 7, 0, 0, 0, 0);
    check("R2 blocked after arm", req_permit, 0);
    ticks(4);
    check("R3 still blocked before last tick", req_permit, 0);
    ticks(1);
    check("R3 free after last tick", req_permit, 1);
    check("R6 irq pulse", timeout_irq, 1);
    step(0, 0, 0, 0, 0, 0);
    check("R6 irq one cycle", timeout_irq, 0);

    // late response carrying the expired label
    step(0, 0, 0, 1, 7, 0);
    check("R8 verdict valid", rsp_done, 1);
    check("R8 expired label dropped", rsp_store, 0);

    // seconds plus fraction: 2*TPS + 3 = 23 ticks
    cfg_sec = 2; cfg_frac = 3;
    step(1, 1, 0, 0, 0, 0);
    ticks(22);
    check("R4 blocked through second rollover", req_permit, 0);
    ticks(1);
    check("R4 free after full seconds count", req_permit, 1);

    // zero timeout
    cfg_sec = 0; cfg_frac = 0;
    step(1, 2, 0, 0, 0, 0);
    check("R5 zero timeout keeps permit", req_permit, 1);
    ticks(3);
    check("R5 no irq with zero timeout", timeout_irq, 0);

    // masked interrupt
    cfg_frac = 2; irq_en = 0;
    step(1, 3, 0, 0, 0, 0);
    ticks(2);
    check("R6 masked expiry frees", req_permit, 1);
    check("R6 masked irq stays low", timeout_irq, 0);
    irq_en = 1;

    // match on the same cycle as the final tick
    cfg_frac = 3;
    step(1, 9, 0, 0, 0, 0);
    ticks(2);
    step(0, 0, 1, 1, 9, 0);
    check("R7 match frees", req_permit, 1);
    check("R7 no irq on match", timeout_irq, 0);
    check("R8 solicited stored", rsp_store, 1);

    // second request while pending is ignored
    cfg_frac = 10;
    step(1, 4, 0, 0, 0, 0);
    step(1, 5, 0, 0, 0, 0);
    check("R11 still blocked", req_permit, 0);
    step(0, 0, 0, 1, 5, 0);
    check("R11 ignored label not solicited", rsp_store, 0);
    check("R11 ignored label no release", req_permit, 0);
    step(0, 0, 0, 1, 4, 0);
    check("R11 original label solicited", rsp_store, 1);
    check("R11 original label releases", req_permit, 1);

    // idle ticks are not banked
    ticks(20);
    cfg_frac = 2;
    step(1, 6, 0, 0, 0, 0);
    ticks(1);
    check("R12 idle ticks not counted", req_permit, 0);
    ticks(1);
    check("R12 expiry exact", req_permit, 1);

    // accept all
    cfg_accept_all = 1;
    step(0, 0, 0, 1, 33, 0);
    check("R9 unsolicited kept", rsp_store, 1);

    // broadcast drop
    cfg_drop_bcast = 1;
    step(0, 0, 0, 1, 33, 1);
    check("R10 broadcast dropped", rsp_store, 0);
    cfg_accept_all = 0; cfg_frac = 10;
    step(1, 3, 0, 0, 0, 0);
    step(0, 0, 0, 1, 3, 1);
    check("R10 broadcast not a match", rsp_store, 0);
    check("R10 broadcast keeps timer", req_permit, 0);
    step(0, 0, 0, 1, 3, 0);
    check("R10 unicast match stored", rsp_store, 1);
    check("R10 unicast match frees", req_permit, 1);
    cfg_drop_bcast = 0;

    // constrained random, compared against the model every cycle
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 50) == 0) begin
        cfg_sec = SW'(($urandom % 4) == 0 ? 1 : 0);
        cfg_frac = FW'($urandom % 7);
        cfg_accept_all = ($urandom % 4) == 0;
        cfg_drop_bcast = ($urandom % 2) == 0;
        irq_en = ($urandom % 4) != 0;
      end
      step(($urandom % 6) == 0, int'($urandom % 4), ($urandom % 2) == 0,
           ($urandom % 5) == 0, int'($urandom % 4), ($urandom % 8) == 0);
    end

    finish_run();
  end

endmodule